// File: doc/BRIEF.md
# Programmable-Depth Tapped Delay Line

This block delays a data word by a selectable number of clock periods, from one up to sixteen. Each rising edge moves the input word into a chain of fifteen storage stages. A tap selector then picks either the live input or one of the fifteen stages, and the chosen word is loaded into a final output register. A 4-bit length code sets the depth. A code of n gives a total delay of n+1 clock periods.

The length code passes through its own register before it reaches the tap selector. The depth can therefore be changed on any cycle. The chain keeps shifting on every edge whatever code is selected, so a change never loses or rewrites stored data. After a change, the output shows the contents of the newly selected tap straight away. There is no refill period.

The data path moves one word on every clock and has no back-pressure, so data and code are plain ports with no valid/ready handshake. Reset is synchronous and active high.

Top module: `tapped_delay_line`

## Requirements
- R1: A synchronous active-high reset clears the fifteen chain stages, the output register and the length register to zero. The output reads 0 on the cycle after a reset edge, and it keeps reading 0 until real data has had time to reach the selected tap.
- R2: With the length code held at value n (0 to 15), the word applied at clock edge k appears on the output just after edge k+n. This is a delay of n+1 periods.
- R3: Code 0 is the shortest path. The live input goes straight into the output register, giving a delay of exactly one period.
- R4: Code 15 is the longest path. The output register is loaded from the fifteenth stage, giving a delay of sixteen periods.
- R5: The length code is captured on a rising edge. The output register first uses that captured value at the following edge, so a new code first affects the output after the second edge on which it is present.
- R6: A change of length code does not flush or refill anything. The first output after the change equals the word the newly selected tap holds, and that word is the input from the matching number of edges earlier.
- R7: The chain shifts on every edge for every code value. Data entered while a short code was selected is still found at the deep taps when a long code is selected later.
- R8: The data width and the maximum depth are parameters, with defaults of 8 bits and 16 periods. The length code width is derived from the depth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 8 | Data word entering the delay line |
| len | input | 4 | Length code, delay = code + 1 periods |
| dout | output | 8 | Registered delayed data word |

## Verification
The hardest situation to reach is a code change where the old tap and the new tap hold different words. Only in that case does a wrong capture edge or a flushed chain become visible on the output. The stimulus therefore drives a new data value on every cycle and toggles the code on consecutive cycles, including jumps between 0 and 15, so that any off-by-one in the code register or the tap index shows up. A separate run applies reset and then selects code 15 at once, to show that the cleared stages, not stale data, come out first.

// File: rtl/tdl_pkg.sv
package tdl_pkg;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned DEPTH_DEF  = 16;

  function automatic int unsigned code_width(input int unsigned depth);
    return (depth <= 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/tdl_chain.sv
module tdl_chain #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 15
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [W-1:0]              din,
  output logic [STAGES:0][W-1:0]    taps
);
  logic [STAGES:1][W-1:0] stage_q;

  // every stage moves on every edge, independent of the selected length
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[1] <= din;
      for (int s = 2; s <= int'(STAGES); s++) begin
        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign taps = {stage_q, din};
endmodule

// File: rtl/tdl_tap_mux.sv
module tdl_tap_mux #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 15,
  parameter int unsigned LW     = 4
) (
  input  logic [STAGES:0][W-1:0] taps,
  input  logic [LW-1:0]          sel,
  output logic [W-1:0]           out
);
  logic [STAGES:0][W-1:0] masked;

  for (genvar i = 0; i <= STAGES; i++) begin : g_tap
    logic hit;
    assign hit       = (sel == LW'(i));
    assign masked[i] = taps[i] & {W{hit}};
  end

  always_comb begin
    out = '0;
    for (int i = 0; i <= int'(STAGES); i++) begin
      out = out | masked[i];
    end
  end
endmodule

// File: rtl/tapped_delay_line.sv
module tapped_delay_line #(
  parameter int unsigned W     = tdl_pkg::DATA_W_DEF,
  parameter int unsigned DEPTH = tdl_pkg::DEPTH_DEF,
  parameter int unsigned LW    = tdl_pkg::code_width(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  din,
  input  logic [LW-1:0] len,
  output logic [W-1:0]  dout
);
  localparam int unsigned STAGES = DEPTH - 1;

  logic [STAGES:0][W-1:0] taps;
  logic [LW-1:0]          len_q;
  logic [W-1:0]           tap_word;

  tdl_chain #(.W(W), .STAGES(STAGES)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .taps (taps)
  );

  // captured code steers the selector on the next edge
  always_ff @(posedge clk) begin
    if (rst) len_q <= '0;
    else     len_q <= len;
  end

  tdl_tap_mux #(.W(W), .STAGES(STAGES), .LW(LW)) u_mux (
    .taps (taps),
    .sel  (len_q),
    .out  (tap_word)
  );

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= tap_word;
  end
endmodule

// File: rtl/tapped_delay_line_checker.sv
module tapped_delay_line_checker #(
  parameter int unsigned W  = 8,
  parameter int unsigned LW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [W-1:0]  din,
  input logic [LW-1:0] len,
  input logic [W-1:0]  dout
);
  logic [4:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (run_cnt != '1)  run_cnt <= run_cnt + 5'd1;
  end

  p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> dout == '0);

  p_code_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd3 && $past(len, 2) == LW'(0)) |-> dout == $past(din, 1));

  p_code_one_r2: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd4 && $past(len, 2) == LW'(1)) |-> dout == $past(din, 2));

  p_code_three_any_history_r6: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd6 && $past(len, 2) == LW'(3)) |-> dout == $past(din, 4));

  p_code_max_r4: assert property (@(posedge clk) disable iff (rst)
    (run_cnt >= 5'd18 && $past(len, 2) == LW'(15)) |-> dout == $past(din, 16));
endmodule

bind tapped_delay_line tapped_delay_line_checker #(.W(W), .LW(LW)) u_chk (
  .clk  (clk),
  .rst  (rst),
  .din  (din),
  .len  (len),
  .dout (dout)
);

// File: tb/tapped_delay_line_test.sv
module tapped_delay_line_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] din = '0;
  logic [3:0] len = '0;
  logic [7:0] dout;

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural model: past inputs, newest first
  logic [7:0] hist [1:15];
  int         code_q = 0;

  always #10 clk = ~clk;

  tapped_delay_line uut (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .len  (len),
    .dout (dout)
  );

  task automatic step(input logic r, input logic [7:0] d, input logic [3:0] c,
                      input string tag);
    logic [7:0] exp;
    rst = r; din = d; len = c;
    if (r)                exp = 8'h00;
    else if (code_q == 0) exp = d;
    else                  exp = hist[code_q];
    if (r) begin
      for (int i = 1; i <= 15; i++) hist[i] = 8'h00;
      code_q = 0;
    end else begin
      for (int i = 15; i >= 2; i--) hist[i] = hist[i-1];
      hist[1] = d;
      code_q  = int'(c);
    end
    @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s: dout=%02h expected=%02h at %0t", tag, dout, exp, $time);
    end
  endtask

  initial begin
    for (int i = 1; i <= 15; i++) hist[i] = 8'h00;
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 8'hA5, 4'd9, "R1");

    // R2/R3/R4: each code held steadily
    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 36; i++) begin
        step(1'b0, 8'(c * 37 + i * 11 + 1), 4'(c),
             (c == 0) ? "R3" : (c == 15) ? "R4" : "R2");
      end
    end

    // R1: reset then immediately longest delay, cleared stages drain first
    step(1'b1, 8'h3C, 4'd15, "R1");
    for (int i = 0; i < 24; i++) step(1'b0, 8'(i + 200), 4'd15, "R1");

    // R5: code changes every cycle
    for (int i = 0; i < 40; i++) step(1'b0, 8'(i * 7 + 3), 4'(i % 16), "R5");

    // R7: alternate between shortest and longest taps
    for (int i = 0; i < 40; i++) begin
      step(1'b0, 8'(i * 13 + 5), ((i / 3) % 2 == 0) ? 4'd0 : 4'd15, "R7");
    end

    // R6: mid-stream changes held a few cycles each
    for (int i = 0; i < 60; i++) begin
      step(1'b0, 8'(255 - i * 3), 4'((i / 4) * 5 % 16), "R6");
    end

    // R8: defaults give 8-bit data, full-width values pass intact
    for (int i = 0; i < 6; i++) step(1'b0, (i % 2 == 0) ? 8'hFF : 8'h00, 4'd2, "R8");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: expected=done actual=hung");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule